// File: doc/BRIEF.md
# Maskable Time-of-Day Alarm with Shared Interrupt / Square-Wave Output

This block watches a running BCD calendar clock and raises alarms when the time lines up with two programmed alarm settings. The first alarm compares seconds, minutes, hours and a day-or-date field. The second compares minutes, hours and day-or-date, and has its seconds fixed at 00. Every compared byte carries a mask bit in its top position. A set mask removes that field from the comparison, so one setting can fire on every tick, every minute, every hour, once a day, or once on a particular weekday or date. Matches are only evaluated on the once-per-second strobe. A match sets a sticky flag that software can clear but never set.

One active-low output is shared by two functions. In interrupt mode it is pulled low while any flag whose enable bit is set remains pending. In wave mode it carries a square wave divided from the crystal-rate strobe: 1 Hz, 4.096 kHz, 8.192 kHz or 32.768 kHz. While the chip runs from its backup supply, the output is released unless a dedicated enable bit permits it.

Software reaches the block through a simple write port and a combinational read port. The alarm bytes use addresses 0-3 (alarm A: seconds, minutes, hours, day/date) and 4-6 (alarm B: minutes, hours, day/date). Address 7 is the control byte and address 8 the flag byte. Every other address reads 0.

Top module: `tod_alarm_irq`

## Requirements
- R1: After reset the control byte (address 7) reads 8'h18, the flag byte (address 8) reads 8'h00 and the alarm bytes read 8'h00. The control fields are bit0 = enable A, bit1 = enable B, bit2 = interrupt mode, bits4:3 = rate code and bit5 = backup-supply output enable. Bits 7:6 of the control byte read 0.
- R2: The alarm bytes at addresses 0-6 read back exactly what was written. Any address above 8 reads 8'h00.
- R3: Alarm A with bit 7 set in all four of its bytes sets flag bit0 on every seconds strobe.
- R4: Alarm A with all masks clear sets flag bit0 only when seconds, minutes, hours and day/date all match on a strobe. A single differing field leaves the flag at 0.
- R5: In a day/date byte, bit 6 = 1 compares bits 5:0 with the day-of-week input, and bit 6 = 0 compares them with the date input.
- R6: The hours comparison covers 7 bits, including the 12-hour mode bit (bit 6) and the PM bit (bit 5). An alarm hour of 8'h52 does not match a time hour of 8'h72.
- R7: Alarm B sets flag bit1 only on strobes where the time seconds equal 00. With all three of its masks set, it fires at second 00 of every minute.
- R8: Flags change only on a seconds strobe or a write to address 8. No flag is set without a strobe.
- R9: Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. If a strobe match and a clearing write land in the same cycle, the flag ends up set.
- R10: In interrupt mode (control bit2 = 1), the output is low exactly while (flag0 AND enable A) OR (flag1 AND enable B), and it stays low until the flag is cleared.
- R11: In wave mode the output period, in crystal-rate strobes, is 2 for rate code 3, 8 for code 2, 16 for code 1 and 2^DIV_W for code 0. With the default DIV_W = 16 these give 32.768 kHz, 8.192 kHz, 4.096 kHz and 1 Hz.
- R12: While on_battery = 1 and control bit5 = 0 the output is high (released). With bit5 = 1 the output behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_stb | input | 1 | Strobe at each half period of the 32.768 kHz crystal (65,536 per second) |
| sec_tick | input | 1 | One-cycle strobe once per second, after the time inputs have advanced |
| cur_sec | input | 7 | Current BCD seconds |
| cur_min | input | 7 | Current BCD minutes |
| cur_hour | input | 7 | Current BCD hours, including 12/24 and PM bits |
| cur_dow | input | 6 | Current day of week |
| cur_date | input | 6 | Current BCD date of month |
| on_battery | input | 1 | High while the chip runs from backup supply |
| reg_addr | input | 4 | Register address for write and read |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq_n | output | 1 | Active-low open-drain enable: 0 pulls the pin low |

## Verification
The bench builds the block with DIV_W = 6. This shrinks the slowest wave tap to a 64-strobe period, so all four rate codes can be measured edge to edge in a short run while the three fast taps keep their true ratios. The crystal strobe is held high during the wave test, so every period can be counted directly in clock cycles. Time inputs are driven as static BCD values around each strobe. This reaches every mask pattern, the day/date switch, the 12-hour bits and the clear-versus-set collision without running a real calendar.

// File: rtl/tod_alarm_pkg.sv
// Shared constants and types for the time-of-day alarm block.
// Assumes: a 4-bit register address space and two alarm sets of four bytes.
package tod_alarm_pkg;
    localparam int NUM_ALARMS = 2;
    localparam int NUM_FIELDS = 4;
    localparam int FLD_SEC    = 0;
    localparam int FLD_MIN    = 1;
    localparam int FLD_HOUR   = 2;
    localparam int FLD_DDATE  = 3;
    localparam int ADDR_W     = 4;

    localparam logic [ADDR_W-1:0] ADDR_B_FIRST = 4'd4;
    localparam logic [ADDR_W-1:0] ADDR_B_LAST  = 4'd6;
    localparam logic [ADDR_W-1:0] ADDR_CTRL    = 4'd7;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS   = 4'd8;

    typedef enum logic [1:0] {
        RATE_SLOW = 2'b00,
        RATE_4K   = 2'b01,
        RATE_8K   = 2'b10,
        RATE_32K  = 2'b11
    } rate_e;

    // Packed control byte: first member is the most significant bit.
    typedef struct packed {
        logic  batt_en;
        rate_e rate;
        logic  irq_mode;
        logic  en_b;
        logic  en_a;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{batt_en: 1'b0, rate: RATE_32K,
                                     irq_mode: 1'b0, en_b: 1'b0, en_a: 1'b0};

    typedef logic [NUM_FIELDS-1:0][7:0] alarm_set_t;
endpackage

// File: rtl/alarm_regs.sv
// Register file: alarm bytes, control byte and the sticky flag byte.
// Assumes: alarm B seconds byte is never written and stays 8'h00, so the
// shared comparator forces alarm B to second 00.
module alarm_regs
    import tod_alarm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr,
    input  logic [7:0]            wdata,
    input  logic [NUM_ALARMS-1:0] match_set,
    output alarm_set_t            alarm_q [NUM_ALARMS],
    output ctrl_t                 ctrl_q,
    output logic [NUM_ALARMS-1:0] flag_q,
    output logic [7:0]            rdata
);
    logic                  al_hit;
    logic                  al_idx;
    logic [1:0]            fld_idx;
    logic [NUM_ALARMS-1:0] flag_clr;
    logic [NUM_ALARMS-1:0] flag_nxt;

    // Decode an address into an alarm set and a field slot.
    always_comb begin
        al_hit  = 1'b0;
        al_idx  = 1'b0;
        fld_idx = 2'd0;
        if (addr < ADDR_B_FIRST) begin
            al_hit  = 1'b1;
            fld_idx = addr[1:0];
        end else if (addr <= ADDR_B_LAST) begin
            al_hit  = 1'b1;
            al_idx  = 1'b1;
            fld_idx = 2'(addr - 4'd3);
        end
    end

    // Next flag value: a strobe match wins over a clearing write.
    always_comb begin
        flag_clr = (wr && addr == ADDR_FLAGS) ? ~wdata[NUM_ALARMS-1:0] : '0;
        flag_nxt = (flag_q & ~flag_clr) | match_set;
    end

    // Register storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < NUM_ALARMS; a++) alarm_q[a] <= '0;
            ctrl_q <= CTRL_RESET;
            flag_q <= '0;
        end else begin
            if (wr && al_hit) alarm_q[al_idx][fld_idx] <= wdata;
            if (wr && addr == ADDR_CTRL) ctrl_q <= ctrl_t'(wdata[5:0]);
            flag_q <= flag_nxt;
        end
    end

    // Combinational read mux.
    always_comb begin
        rdata = 8'h00;
        if (al_hit)                  rdata = alarm_q[al_idx][fld_idx];
        else if (addr == ADDR_CTRL)  rdata = {2'b00, ctrl_q};
        else if (addr == ADDR_FLAGS) rdata = {{(8-NUM_ALARMS){1'b0}}, flag_q};
    end
endmodule

// File: rtl/alarm_cmp.sv
// Compares one alarm set with the current time. Bit 7 of each byte masks
// that field. Bit 6 of the day/date byte selects day-of-week over date.
// Assumes: alarm hours are entered in the same 12/24 mode as the clock.
module alarm_cmp
    import tod_alarm_pkg::*;
(
    input  alarm_set_t  al,
    input  logic [6:0]  cur_sec,
    input  logic [6:0]  cur_min,
    input  logic [6:0]  cur_hour,
    input  logic [5:0]  cur_dow,
    input  logic [5:0]  cur_date,
    output logic        hit
);
    logic sec_ok, min_ok, hour_ok, dd_ok;

    // Per-field match, each overridden by its mask bit.
    always_comb begin
        sec_ok  = al[FLD_SEC][7]  || (al[FLD_SEC][6:0]  == cur_sec);
        min_ok  = al[FLD_MIN][7]  || (al[FLD_MIN][6:0]  == cur_min);
        hour_ok = al[FLD_HOUR][7] || (al[FLD_HOUR][6:0] == cur_hour);
        dd_ok   = al[FLD_DDATE][7] ||
                  (al[FLD_DDATE][6] ? (al[FLD_DDATE][5:0] == cur_dow)
                                    : (al[FLD_DDATE][5:0] == cur_date));
        hit     = sec_ok && min_ok && hour_ok && dd_ok;
    end
endmodule

// File: rtl/sqw_div.sv
// Free-running divider of the crystal half-period strobe, with a tap chosen
// by the rate code. Assumes DIV_W >= 5 so that the fixed fast taps exist.
module sqw_div
    import tod_alarm_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  osc_stb,
    input  rate_e rate,
    output logic  wave
);
    localparam int TAP_32K  = 0;
    localparam int TAP_8K   = 2;
    localparam int TAP_4K   = 3;
    localparam int TAP_SLOW = DIV_W - 1;

    logic [DIV_W-1:0] cnt_q;

    // Count crystal strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (osc_stb) cnt_q <= cnt_q + 1'b1;
    end

    // Pick the divider tap for the selected rate.
    always_comb begin
        unique case (rate)
            RATE_SLOW: wave = cnt_q[TAP_SLOW];
            RATE_4K:   wave = cnt_q[TAP_4K];
            RATE_8K:   wave = cnt_q[TAP_8K];
            default:   wave = cnt_q[TAP_32K];
        endcase
    end
endmodule

// File: rtl/tod_alarm_irq.sv
// Top: two maskable alarms, sticky flags and one shared active-low output
// that carries either the alarm interrupt or a divided square wave.
// Assumes: time inputs are stable BCD whenever sec_tick is high.
module tod_alarm_irq
    import tod_alarm_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        osc_stb,
    input  logic        sec_tick,
    input  logic [6:0]  cur_sec,
    input  logic [6:0]  cur_min,
    input  logic [6:0]  cur_hour,
    input  logic [5:0]  cur_dow,
    input  logic [5:0]  cur_date,
    input  logic        on_battery,
    input  logic [3:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        irq_n
);
    alarm_set_t            alarm_q [NUM_ALARMS];
    ctrl_t                 ctrl_q;
    logic [NUM_ALARMS-1:0] flag_q;
    logic [NUM_ALARMS-1:0] hit;
    logic [NUM_ALARMS-1:0] match_set;
    logic                  wave;
    logic                  irq_mode_q;
    logic                  batt_en_q;
    logic                  pend;

    alarm_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .match_set (match_set),
        .alarm_q   (alarm_q),
        .ctrl_q    (ctrl_q),
        .flag_q    (flag_q),
        .rdata     (reg_rdata)
    );

    for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_cmp
        alarm_cmp i_cmp (
            .al       (alarm_q[g]),
            .cur_sec  (cur_sec),
            .cur_min  (cur_min),
            .cur_hour (cur_hour),
            .cur_dow  (cur_dow),
            .cur_date (cur_date),
            .hit      (hit[g])
        );
    end

    sqw_div #(.DIV_W(DIV_W)) i_sqw (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_stb (osc_stb),
        .rate    (ctrl_q.rate),
        .wave    (wave)
    );

    // Output selection: backup gating, then interrupt or wave mode.
    always_comb begin
        match_set  = hit & {NUM_ALARMS{sec_tick}};
        irq_mode_q = ctrl_q.irq_mode;
        batt_en_q  = ctrl_q.batt_en;
        pend       = (flag_q[0] && ctrl_q.en_a) || (flag_q[1] && ctrl_q.en_b);
        if (on_battery && !ctrl_q.batt_en) irq_n = 1'b1;
        else if (ctrl_q.irq_mode)           irq_n = !pend;
        else                                irq_n = wave;
    end
endmodule

// File: rtl/tod_alarm_irq_chk.sv
// Checker for tod_alarm_irq: flag timing, interrupt hold and backup gating.
module tod_alarm_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       reg_wr,
    input logic [3:0] reg_addr,
    input logic       on_battery,
    input logic       irq_n,
    input logic [1:0] flag_q,
    input logic       irq_mode_q,
    input logic       batt_en_q
);
    // R8: a flag rises only on a cycle with the seconds strobe
    a_r8_flag_a_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[0]) |-> $past(sec_tick));
    a_r8_flag_b_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[1]) |-> $past(sec_tick));
    // R9: a flag falls only after a write to the flag byte
    a_r9_flag_a_fall_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q[0]) |-> $past(reg_wr && reg_addr == 4'd8));
    a_r9_flag_b_fall_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q[1]) |-> $past(reg_wr && reg_addr == 4'd8));
    // R10: an asserted interrupt holds until some register write happens
    a_r10_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && irq_mode_q && !reg_wr && !on_battery) |=> (!irq_n || on_battery));
    // R12: on backup power without permission the output is released
    a_r12_batt_release: assert property (@(posedge clk) disable iff (!rst_n)
        (on_battery && !batt_en_q) |-> irq_n);
endmodule

bind tod_alarm_irq tod_alarm_irq_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .on_battery (on_battery),
    .irq_n      (irq_n),
    .flag_q     (flag_q),
    .irq_mode_q (irq_mode_q),
    .batt_en_q  (batt_en_q)
);

// File: tb/test_tod_alarm_irq.sv
// Directed bench: one task per scenario, each checking its own results.
module test_tod_alarm_irq;
    localparam int DIV_W = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_stb = 1'b0;
    logic       sec_tick = 1'b0;
    logic [6:0] cur_sec = '0;
    logic [6:0] cur_min = '0;
    logic [6:0] cur_hour = '0;
    logic [5:0] cur_dow = '0;
    logic [5:0] cur_date = '0;
    logic       on_battery = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    tod_alarm_irq #(.DIV_W(DIV_W)) i_tod_alarm_irq (.*);

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic set_time(input logic [6:0] s, input logic [6:0] m, input logic [6:0] h,
                            input logic [5:0] dw, input logic [5:0] dt);
        cur_sec = s; cur_min = m; cur_hour = h; cur_dow = dw; cur_date = dt;
    endtask

    task automatic expect_flags(input logic [7:0] exp, input logic [7:0] msk, input string req);
        logic [7:0] v;
        rd(4'd8, v);
        check((v & msk) == (exp & msk), req, v & msk, exp & msk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(4'd7, v); check(v == 8'h18, "R1 ctrl", v, 8'h18);
        rd(4'd8, v); check(v == 8'h00, "R1 flags", v, 8'h00);
        rd(4'd2, v); check(v == 8'h00, "R1 alarm byte", v, 8'h00);
    endtask

    task automatic t_readback();
        logic [7:0] v;
        wr(4'd1, 8'hA5); rd(4'd1, v); check(v == 8'hA5, "R2 alarm A min", v, 8'hA5);
        wr(4'd6, 8'h5C); rd(4'd6, v); check(v == 8'h5C, "R2 alarm B ddate", v, 8'h5C);
        wr(4'd9, 8'h77); rd(4'd9, v); check(v == 8'h00, "R2 unmapped", v, 8'h00);
        wr(4'd7, 8'hD8); rd(4'd7, v); check(v == 8'h18, "R1 ctrl top bits", v, 8'h18);
        for (int a = 0; a < 7; a++) wr(4'(a), 8'h00);
    endtask

    task automatic t_every_sec();
        for (int a = 0; a < 4; a++) wr(4'(a), 8'h80);
        set_time(7'h17, 7'h42, 7'h09, 6'd2, 6'h05);
        tick(); expect_flags(8'h01, 8'h01, "R3 first tick");
        wr(4'd8, 8'h00); expect_flags(8'h00, 8'h01, "R9 cleared");
        cur_sec = 7'h18; tick(); expect_flags(8'h01, 8'h01, "R3 second tick");
        wr(4'd8, 8'h00);
        repeat (10) @(negedge clk);
        expect_flags(8'h00, 8'h01, "R8 no strobe no flag");
    endtask

    task automatic t_full_match();
        wr(4'd0, 8'h30); wr(4'd1, 8'h15); wr(4'd2, 8'h08); wr(4'd3, 8'h12);
        wr(4'd8, 8'h00);
        set_time(7'h30, 7'h15, 7'h08, 6'd3, 6'h13); tick();
        expect_flags(8'h00, 8'h01, "R4 date differs");
        set_time(7'h31, 7'h15, 7'h08, 6'd3, 6'h12); tick();
        expect_flags(8'h00, 8'h01, "R4 seconds differ");
        set_time(7'h30, 7'h15, 7'h08, 6'd3, 6'h12); tick();
        expect_flags(8'h01, 8'h01, "R4 full match");
        wr(4'd8, 8'h00);
    endtask

    task automatic t_daydate();
        wr(4'd3, 8'h43);
        set_time(7'h30, 7'h15, 7'h08, 6'd4, 6'h03); tick();
        expect_flags(8'h00, 8'h01, "R5 day select ignores date");
        set_time(7'h30, 7'h15, 7'h08, 6'd3, 6'h12); tick();
        expect_flags(8'h01, 8'h01, "R5 day select match");
        wr(4'd8, 8'h00);
        wr(4'd3, 8'h80);
    endtask

    task automatic t_hour_bits();
        wr(4'd2, 8'h52);
        set_time(7'h30, 7'h15, 7'h72, 6'd3, 6'h12); tick();
        expect_flags(8'h00, 8'h01, "R6 PM bit differs");
        cur_hour = 7'h52; tick();
        expect_flags(8'h01, 8'h01, "R6 12h hour match");
        wr(4'd8, 8'h00);
    endtask

    task automatic t_alarm_b();
        wr(4'd4, 8'h80); wr(4'd5, 8'h80); wr(4'd6, 8'h80);
        set_time(7'h05, 7'h20, 7'h10, 6'd1, 6'h01); tick();
        expect_flags(8'h00, 8'h02, "R7 nonzero seconds");
        cur_sec = 7'h00; tick();
        expect_flags(8'h02, 8'h02, "R7 second 00");
        wr(4'd8, 8'h00);
        wr(4'd4, 8'h15); wr(4'd5, 8'h08);
        set_time(7'h00, 7'h16, 7'h08, 6'd1, 6'h01); tick();
        expect_flags(8'h00, 8'h02, "R7 minutes differ");
        cur_min = 7'h15; tick();
        expect_flags(8'h02, 8'h02, "R7 field match");
        wr(4'd8, 8'h00);
    endtask

    task automatic t_sticky();
        for (int a = 0; a < 7; a++) wr(4'(a), 8'h80);
        set_time(7'h00, 7'h01, 7'h01, 6'd1, 6'h01); tick();
        expect_flags(8'h03, 8'hFF, "R3 R7 both set");
        wr(4'd8, 8'h03); expect_flags(8'h03, 8'hFF, "R9 write ones keeps");
        wr(4'd8, 8'h02); expect_flags(8'h02, 8'hFF, "R9 clear bit0 only");
        wr(4'd8, 8'h00); expect_flags(8'h00, 8'hFF, "R9 clear all");
        @(negedge clk);
        reg_addr = 4'd8; reg_wdata = 8'h00; reg_wr = 1'b1; sec_tick = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; sec_tick = 1'b0;
        expect_flags(8'h03, 8'hFF, "R9 set wins over clear");
        wr(4'd8, 8'h00);
    endtask

    task automatic t_irq();
        wr(4'd7, 8'h05);
        #1 check(irq_n == 1'b1, "R10 idle high", irq_n, 1);
        cur_sec = 7'h01; tick();
        #1 check(irq_n == 1'b0, "R10 flag A asserts", irq_n, 0);
        repeat (5) @(negedge clk);
        check(irq_n == 1'b0, "R10 stays low", irq_n, 0);
        wr(4'd8, 8'h00);
        #1 check(irq_n == 1'b1, "R10 released on clear", irq_n, 1);
        wr(4'd7, 8'h06); tick();
        #1 check(irq_n == 1'b1, "R10 flag A masked", irq_n, 1);
        cur_sec = 7'h00; tick();
        #1 check(irq_n == 1'b0, "R10 flag B asserts", irq_n, 0);
        wr(4'd8, 8'h00);
    endtask

    task automatic t_battery();
        wr(4'd7, 8'h05); cur_sec = 7'h01; tick();
        on_battery = 1'b1;
        #1 check(irq_n == 1'b1, "R12 gated on backup", irq_n, 1);
        wr(4'd7, 8'h25);
        #1 check(irq_n == 1'b0, "R12 allowed on backup", irq_n, 0);
        on_battery = 1'b0;
        wr(4'd8, 8'h00);
        wr(4'd7, 8'h00);
    endtask

    task automatic t_square(input logic [1:0] code, input int exp);
        int n;
        wr(4'd7, {3'b000, code, 3'b000});
        osc_stb = 1'b1;
        n = 0;
        while (irq_n !== 1'b0 && n < 500) begin @(negedge clk); n++; end
        while (irq_n !== 1'b1 && n < 500) begin @(negedge clk); n++; end
        n = 0;
        do begin @(negedge clk); n++; end while (irq_n !== 1'b0 && n < 500);
        while (irq_n !== 1'b1 && n < 500) begin @(negedge clk); n++; end
        check(n == exp, $sformatf("R11 rate code %0d period", code), n, exp);
        osc_stb = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_every_sec();
        t_full_match();
        t_daydate();
        t_hour_bits();
        t_alarm_b();
        t_sticky();
        t_irq();
        t_battery();
        t_square(2'd3, 2);
        t_square(2'd2, 8);
        t_square(2'd1, 16);
        t_square(2'd0, 1 << DIV_W);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule